// File: doc/BRIEF.md
# Oldest-First Op-Class Issue Selector

This block picks which ready instructions leave an out-of-order scheduler in each clock cycle. Ready entries come in with a sequence number and an operation class. Each class keeps its own small ready pool, and the oldest entry of each pool is that class's candidate. In every cycle the candidates are ranked by age, smallest sequence number first. They are then taken in that order until the issue width is filled or no candidate is left. At most one entry per class is granted in a cycle.

Each class has a parameterised number of functional units and an issue latency.
- A class with no units issues without any unit check.
- A class whose issue latency is one frees its unit again for the next cycle.
- A class with a longer issue latency holds the unit until a countdown expires, and then reports a release.

A candidate whose units are all held is skipped, and an event is flagged for it. The next class in age order can then take the slot. Grants, releases, busy events and the issued count are all registered.

Top module: `isq_issue_select`

## Requirements
- R1: After synchronous reset the outputs iss_valid, iss_seq, iss_class, iss_count, unit_release and fu_stall are all zero.
- R2: At most ISSUE_WIDTH grants are reported per cycle. They fill slots from slot 0 upward with no gaps, and an unused slot shows zero valid, zero sequence and zero class.
- R3: Candidates are visited in order of their class's smallest ready sequence number, with a tie going to the lower class index. Grants appear in slot order in that same order, and visiting stops once the width is filled or the candidates run out.
- R4: A class receives at most one grant per cycle, and the granted entry is the smallest sequence number held for that class.
- R5: An entry pushed on port p is stored at a clock edge. Its class index is the push_class field bits [p*CLS_W +: CLS_W]. Its sequence number is push_seq bits [p*SEQ_W +: SEQ_W]. It can be selected in the following cycle, so its grant shows on the outputs one edge after it was stored at the earliest.
- R6: A class configured with zero units is granted whenever it is visited. It never raises fu_stall and never raises unit_release.
- R7: When a visited class has all its units held, it gets no grant and its fu_stall bit pulses for one cycle. Younger classes may use the free slot. A class not visited because the width was already filled does not raise fu_stall.
- R8: For a class with units and issue latency one, its unit_release bit pulses in the same cycle that its grant appears.
- R9: For a class with issue latency L greater than one, the granted unit stays held. Its unit_release bit pulses L-1 cycles after the grant appears. That unit can be granted again so that the new grant appears in the cycle after the pulse at the earliest.
- R10: iss_count equals the number of valid grant slots in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | PUSH_PORTS | Per-port ready-entry push strobe |
| push_seq | input | PUSH_PORTS*SEQ_W | Per-port sequence number (smaller is older) |
| push_class | input | PUSH_PORTS*CLS_W | Per-port operation class index |
| iss_valid | output | ISSUE_WIDTH | Per-slot grant valid |
| iss_seq | output | ISSUE_WIDTH*SEQ_W | Per-slot granted sequence number |
| iss_class | output | ISSUE_WIDTH*CLS_W | Per-slot granted class index |
| iss_count | output | CNT_W | Number of grants this cycle |
| unit_release | output | NUM_CLASSES | Per-class unit release event |
| fu_stall | output | NUM_CLASSES | Per-class busy-skip event |

## Verification
Several properties are checked by assertions on every cycle:
- the grant slots are packed;
- the issued count matches the valid slots;
- slot order follows age with the class tie-break;
- a unit-less class never stalls;
- a held unit is never granted;
- no ready pool is pushed past its depth or popped while empty.

Other behaviour can only be shown by the bench's scenarios, which compare every output on every clock against a behavioural model:
- that the granted entry really is the oldest of its class;
- that an older late arrival overtakes the existing ones;
- the exact cycle of a release pulse after a multi-cycle grant;
- that classes beyond the width raise no stall.

// File: rtl/isq_pkg.sv
package isq_pkg;

  // Age rank used by the selector and by the output-order checks:
  // a smaller sequence number is older, equal ages favour the lower class.
  function automatic logic is_older(input logic [31:0] a_seq, input logic [31:0] a_cls,
                                    input logic [31:0] b_seq, input logic [31:0] b_cls);
    return (a_seq < b_seq) || ((a_seq == b_seq) && (a_cls < b_cls));
  endfunction

endpackage

// File: rtl/isq_ready_bank.sv
module isq_ready_bank #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int PORTS = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PORTS-1:0]       wr_en,
  input  logic [PORTS*SEQ_W-1:0] wr_seq,
  input  logic                   rd_en,
  output logic                   has_entry,
  output logic [SEQ_W-1:0]       head_seq
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SEQ_W-1:0] seq_mem [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [IW-1:0]    head_idx;
  logic [IW-1:0]    wr_idx [PORTS];
  logic [PORTS-1:0] wr_ok;

  // Oldest held entry: linear minimum search over the valid slots.
  always_comb begin
    has_entry = 1'b0;
    head_idx  = '0;
    head_seq  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && (!has_entry || (seq_mem[i] < head_seq))) begin
        has_entry = 1'b1;
        head_idx  = IW'(i);
        head_seq  = seq_mem[i];
      end
    end
  end

  // Each writing port claims the lowest slot still free after earlier ports.
  always_comb begin
    logic [DEPTH-1:0] used;
    used = vld_q;
    for (int p = 0; p < PORTS; p++) begin
      wr_ok[p]  = 1'b0;
      wr_idx[p] = '0;
      if (wr_en[p]) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (!used[i] && !wr_ok[p]) begin
            wr_ok[p]  = 1'b1;
            wr_idx[p] = IW'(i);
          end
        end
      end
      if (wr_ok[p]) used[wr_idx[p]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      if (rd_en) vld_q[head_idx] <= 1'b0;
      for (int p = 0; p < PORTS; p++) begin
        if (wr_ok[p]) vld_q[wr_idx[p]] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < PORTS; p++) begin
      if (wr_ok[p]) seq_mem[wr_idx[p]] <= wr_seq[p*SEQ_W +: SEQ_W];
    end
  end

  // R4: a pop only ever targets an occupied pool
  a_r4_pop_has_entry: assert property (@(posedge clk) disable iff (rst) rd_en |-> has_entry);

  for (genvar p = 0; p < PORTS; p++) begin : g_room
    // R5: every push finds storage
    a_r5_push_has_room: assert property (@(posedge clk) disable iff (rst) wr_en[p] |-> wr_ok[p]);
  end

endmodule

// File: rtl/isq_unit_pool.sv
module isq_unit_pool #(
  parameter int UNITS = 1,
  parameter int ILAT  = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  output logic avail,
  output logic release_q
);
  logic rel_now;

  if (ILAT <= 1) begin : g_pipe
    // One grant per class per cycle never exceeds a unit freed every cycle.
    assign avail   = 1'b1;
    assign rel_now = take;
  end else begin : g_hold
    localparam int TW = $clog2(ILAT);

    logic [TW-1:0]    tmr [UNITS];
    logic [UNITS-1:0] busy, ending, pick;

    always_comb begin
      pick = '0;
      for (int u = 0; u < UNITS; u++) begin
        busy[u]   = (tmr[u] != '0);
        ending[u] = (tmr[u] == TW'(1));
      end
      for (int u = UNITS - 1; u >= 0; u--) begin
        if (!busy[u]) pick = UNITS'(1) << u;
      end
    end

    assign avail   = |(~busy);
    assign rel_now = |ending;

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int u = 0; u < UNITS; u++) tmr[u] <= '0;
      end else begin
        for (int u = 0; u < UNITS; u++) begin
          if (take && pick[u])  tmr[u] <= TW'(ILAT - 1);
          else if (busy[u])     tmr[u] <= tmr[u] - TW'(1);
        end
      end
    end

    // R9: a held unit is never handed out again
    a_r9_take_needs_free: assert property (@(posedge clk) disable iff (rst) take |-> avail);
    // R9: a fresh grant adds one held unit when nothing is retiring
    a_r9_hold_grows: assert property (@(posedge clk) disable iff (rst)
      (take && !rel_now) |=> ($countones(busy) == $countones($past(busy)) + 1));
  end

  always_ff @(posedge clk) begin
    if (rst) release_q <= 1'b0;
    else     release_q <= rel_now;
  end

endmodule

// File: rtl/isq_age_select.sv
module isq_age_select #(
  parameter int NCLS  = 4,
  parameter int WIDTH = 2,
  parameter int SEQ_W = 16,
  localparam int CLS_W = (NCLS > 1) ? $clog2(NCLS) : 1,
  localparam int PW    = $clog2(NCLS + 1)
) (
  input  logic [NCLS-1:0]        ready,
  input  logic [NCLS*SEQ_W-1:0]  head,
  input  logic [NCLS-1:0]        avail,
  output logic [NCLS-1:0]        grant,
  output logic [NCLS-1:0]        stall,
  output logic [WIDTH-1:0]       slot_valid,
  output logic [WIDTH*SEQ_W-1:0] slot_seq,
  output logic [WIDTH*CLS_W-1:0] slot_class
);
  logic [PW-1:0] pos [NCLS];

  // Slot position of a class = count of issuable classes that rank older.
  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      int ahead;
      ahead = 0;
      for (int j = 0; j < NCLS; j++) begin
        if (j != c && ready[j] && avail[j] &&
            isq_pkg::is_older(32'(head[j*SEQ_W +: SEQ_W]), 32'(j),
                              32'(head[c*SEQ_W +: SEQ_W]), 32'(c)))
          ahead = ahead + 1;
      end
      pos[c]   = PW'(ahead);
      grant[c] = ready[c] && (ahead < WIDTH) && avail[c];
      stall[c] = ready[c] && (ahead < WIDTH) && !avail[c];
    end
  end

  always_comb begin
    slot_valid = '0;
    slot_seq   = '0;
    slot_class = '0;
    for (int k = 0; k < WIDTH; k++) begin
      for (int c = 0; c < NCLS; c++) begin
        if (grant[c] && (int'(pos[c]) == k)) begin
          slot_valid[k]                  = 1'b1;
          slot_seq[k*SEQ_W +: SEQ_W]     = head[c*SEQ_W +: SEQ_W];
          slot_class[k*CLS_W +: CLS_W]   = CLS_W'(c);
        end
      end
    end
  end

endmodule

// File: rtl/isq_issue_select.sv
module isq_issue_select #(
  parameter int NUM_CLASSES = 4,
  parameter int ISSUE_WIDTH = 2,
  parameter int PUSH_PORTS  = 2,
  parameter int QDEPTH      = 8,
  parameter int SEQ_W       = 16,
  parameter int CFG_W       = 4,
  parameter logic [NUM_CLASSES*CFG_W-1:0] CLASS_UNITS = 16'h2120,
  parameter logic [NUM_CLASSES*CFG_W-1:0] CLASS_ILAT  = 16'h2311,
  localparam int CLS_W = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
  localparam int CNT_W = $clog2(ISSUE_WIDTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [PUSH_PORTS-1:0]        push_valid,
  input  logic [PUSH_PORTS*SEQ_W-1:0]  push_seq,
  input  logic [PUSH_PORTS*CLS_W-1:0]  push_class,
  output logic [ISSUE_WIDTH-1:0]       iss_valid,
  output logic [ISSUE_WIDTH*SEQ_W-1:0] iss_seq,
  output logic [ISSUE_WIDTH*CLS_W-1:0] iss_class,
  output logic [CNT_W-1:0]             iss_count,
  output logic [NUM_CLASSES-1:0]       unit_release,
  output logic [NUM_CLASSES-1:0]       fu_stall
);
  logic [NUM_CLASSES-1:0]       cls_ready, cls_avail, cls_grant, cls_stall;
  logic [NUM_CLASSES*SEQ_W-1:0] cls_head;
  logic [ISSUE_WIDTH-1:0]       slot_valid;
  logic [ISSUE_WIDTH*SEQ_W-1:0] slot_seq;
  logic [ISSUE_WIDTH*CLS_W-1:0] slot_class;

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    localparam int UNITS = int'(CLASS_UNITS[c*CFG_W +: CFG_W]);
    localparam int ILAT  = int'(CLASS_ILAT[c*CFG_W +: CFG_W]);

    logic [PUSH_PORTS-1:0] wr_en;
    always_comb begin
      for (int p = 0; p < PUSH_PORTS; p++)
        wr_en[p] = push_valid[p] && (push_class[p*CLS_W +: CLS_W] == CLS_W'(c));
    end

    isq_ready_bank #(.DEPTH(QDEPTH), .SEQ_W(SEQ_W), .PORTS(PUSH_PORTS)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .wr_seq    (push_seq),
      .rd_en     (cls_grant[c]),
      .has_entry (cls_ready[c]),
      .head_seq  (cls_head[c*SEQ_W +: SEQ_W])
    );

    if (UNITS == 0) begin : g_nofu
      assign cls_avail[c]    = 1'b1;
      assign unit_release[c] = 1'b0;
      // R6: a class without units is never reported busy
      a_r6_nofu_no_stall: assert property (@(posedge clk) disable iff (rst) !fu_stall[c]);
    end else begin : g_fu
      isq_unit_pool #(.UNITS(UNITS), .ILAT(ILAT)) u_pool (
        .clk       (clk),
        .rst       (rst),
        .take      (cls_grant[c]),
        .avail     (cls_avail[c]),
        .release_q (unit_release[c])
      );
    end
  end

  isq_age_select #(.NCLS(NUM_CLASSES), .WIDTH(ISSUE_WIDTH), .SEQ_W(SEQ_W)) u_sel (
    .ready      (cls_ready),
    .head       (cls_head),
    .avail      (cls_avail),
    .grant      (cls_grant),
    .stall      (cls_stall),
    .slot_valid (slot_valid),
    .slot_seq   (slot_seq),
    .slot_class (slot_class)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= '0;
      iss_seq   <= '0;
      iss_class <= '0;
      iss_count <= '0;
      fu_stall  <= '0;
    end else begin
      iss_valid <= slot_valid;
      iss_seq   <= slot_seq;
      iss_class <= slot_class;
      iss_count <= CNT_W'($countones(slot_valid));
      fu_stall  <= cls_stall;
    end
  end

  // R2: grants occupy a gap-free run of slots starting at slot 0
  a_r2_packed_slots: assert property (@(posedge clk) disable iff (rst)
    ((iss_valid & (iss_valid + ISSUE_WIDTH'(1))) == '0));

  // R10: reported count agrees with the valid slots
  a_r10_count_matches: assert property (@(posedge clk) disable iff (rst)
    (32'(iss_count) == $countones(iss_valid)));

  for (genvar k = 1; k < ISSUE_WIDTH; k++) begin : g_order
    // R3: each later slot holds a younger candidate than the slot before it
    a_r3_slot_age_order: assert property (@(posedge clk) disable iff (rst)
      iss_valid[k] |-> isq_pkg::is_older(32'(iss_seq[(k-1)*SEQ_W +: SEQ_W]),
                                         32'(iss_class[(k-1)*CLS_W +: CLS_W]),
                                         32'(iss_seq[k*SEQ_W +: SEQ_W]),
                                         32'(iss_class[k*CLS_W +: CLS_W])));
  end

endmodule

// File: tb/isq_issue_select_test.sv
module isq_issue_select_test;
  localparam int NC = 4;
  localparam int W  = 2;
  localparam int P  = 2;
  localparam int QD = 8;
  localparam int SW = 16;
  localparam int CW = 2;
  localparam int NW = 2;
  localparam int MU = 2;

  // Bench-side configuration: units and issue latency per class.
  int cfg_units [NC] = '{0, 2, 1, 2};
  int cfg_ilat  [NC] = '{1, 1, 3, 2};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [P-1:0]    push_valid = '0;
  logic [P*SW-1:0] push_seq   = '0;
  logic [P*CW-1:0] push_class = '0;
  logic [W-1:0]    iss_valid;
  logic [W*SW-1:0] iss_seq;
  logic [W*CW-1:0] iss_class;
  logic [NW-1:0]   iss_count;
  logic [NC-1:0]   unit_release, fu_stall;

  always #2.5ns clk = ~clk;

  isq_issue_select #(
    .NUM_CLASSES(NC), .ISSUE_WIDTH(W), .PUSH_PORTS(P), .QDEPTH(QD), .SEQ_W(SW), .CFG_W(4),
    .CLASS_UNITS(16'h2120), .CLASS_ILAT(16'h2311)
  ) uut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_seq(push_seq),
    .push_class(push_class), .iss_valid(iss_valid), .iss_seq(iss_seq),
    .iss_class(iss_class), .iss_count(iss_count), .unit_release(unit_release),
    .fu_stall(fu_stall)
  );

  // ---------------- behavioural reference ----------------
  int  rq_seq [NC][QD];
  bit  rq_v   [NC][QD];
  int  tmr    [NC][MU];
  logic [W-1:0]    exp_valid;
  logic [W*SW-1:0] exp_seq;
  logic [W*CW-1:0] exp_cls;
  logic [NC-1:0]   exp_rel, exp_stall;
  int              exp_cnt;

  always @(posedge clk) begin : ref_model
    int  oldest [NC];
    bit  has [NC];
    bit  seen [NC];
    int  alloc [NC];
    int  slot;
    if (rst) begin
      for (int c = 0; c < NC; c++) begin
        for (int i = 0; i < QD; i++) rq_v[c][i] = 1'b0;
        for (int u = 0; u < MU; u++) tmr[c][u] = 0;
      end
      exp_valid = '0; exp_seq = '0; exp_cls = '0; exp_rel = '0; exp_stall = '0; exp_cnt = 0;
    end else begin
      exp_valid = '0; exp_seq = '0; exp_cls = '0; exp_rel = '0; exp_stall = '0; exp_cnt = 0;
      for (int c = 0; c < NC; c++) begin
        has[c] = 1'b0; oldest[c] = 0; seen[c] = 1'b0; alloc[c] = -1;
        for (int i = 0; i < QD; i++)
          if (rq_v[c][i] && (!has[c] || rq_seq[c][i] < oldest[c])) begin
            has[c] = 1'b1; oldest[c] = rq_seq[c][i];
          end
      end
      slot = 0;
      for (int step = 0; step < NC; step++) begin
        int best;
        bit ok;
        best = -1;
        for (int c = 0; c < NC; c++)
          if (has[c] && !seen[c] && (best < 0 || oldest[c] < oldest[best])) best = c;
        if (best < 0 || slot == W) break;
        seen[best] = 1'b1;
        ok = 1'b0;
        if (cfg_units[best] == 0) ok = 1'b1;
        else if (cfg_ilat[best] <= 1) begin ok = 1'b1; exp_rel[best] = 1'b1; end
        else begin
          for (int u = 0; u < cfg_units[best]; u++)
            if (!ok && tmr[best][u] == 0) begin ok = 1'b1; alloc[best] = u; end
        end
        if (ok) begin
          bit gone;
          exp_valid[slot] = 1'b1;
          exp_seq[slot*SW +: SW] = SW'(oldest[best]);
          exp_cls[slot*CW +: CW] = CW'(best);
          slot++;
          gone = 1'b0;
          for (int i = 0; i < QD; i++)
            if (!gone && rq_v[best][i] && rq_seq[best][i] == oldest[best]) begin
              rq_v[best][i] = 1'b0; gone = 1'b1;
            end
        end else begin
          exp_stall[best] = 1'b1;
        end
      end
      exp_cnt = slot;
      for (int c = 0; c < NC; c++) begin
        if (cfg_ilat[c] > 1) begin
          for (int u = 0; u < cfg_units[c]; u++) begin
            if (tmr[c][u] == 1) exp_rel[c] = 1'b1;
            if (tmr[c][u] > 0) tmr[c][u] = tmr[c][u] - 1;
          end
          if (alloc[c] >= 0) tmr[c][alloc[c]] = cfg_ilat[c] - 1;
        end
      end
      for (int p = 0; p < P; p++) begin
        if (push_valid[p]) begin
          int c;
          bit put;
          c = int'(push_class[p*CW +: CW]);
          put = 1'b0;
          for (int i = 0; i < QD; i++)
            if (!put && !rq_v[c][i]) begin
              rq_v[c][i] = 1'b1; rq_seq[c][i] = int'(push_seq[p*SW +: SW]); put = 1'b1;
            end
        end
      end
    end
  end

  // ---------------- checking ----------------
  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 R3 R4 grant slots", 64'({iss_valid, iss_seq, iss_class}),
        64'({exp_valid, exp_seq, exp_cls}));
    chk("R8 R9 unit release", 64'(unit_release), 64'(exp_rel));
    chk("R6 R7 busy skip", 64'(fu_stall), 64'(exp_stall));
    chk("R10 issued count", 64'(iss_count), 64'(exp_cnt));
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic set_push(input int p, input int cls, input int seq);
    push_valid[p] = 1'b1;
    push_class[p*CW +: CW] = CW'(cls);
    push_seq[p*SW +: SW]   = SW'(seq);
  endtask

  task automatic clr_push();
    push_valid = '0; push_class = '0; push_seq = '0;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      report();
      $finish;
    end
  end

  initial begin : stimulus
    @(negedge clk);
    @(negedge clk);
    // R1: reset state of every output
    chk("R1 reset grants", 64'({iss_valid, iss_seq, iss_class}), 64'(0));
    chk("R1 reset count/release/stall", 64'({iss_count, unit_release, fu_stall}), 64'(0));
    rst = 1'b0;
    repeat (2) step();

    // R5 and R8: single push to pipelined class 1
    set_push(0, 1, 100);
    step();
    clr_push();
    chk("R5 no grant before entry is selectable", 64'(iss_valid), 64'(0));
    step();
    chk("R5 grant one edge after storage", 64'({iss_valid[0], iss_class[CW-1:0], iss_seq[SW-1:0]}),
        64'({1'b1, 2'd1, 16'd100}));
    chk("R8 release with pipelined grant", 64'(unit_release[1]), 64'(1));

    // R9: two entries on the non-pipelined class 2, with class 1 filling the slot meanwhile
    set_push(0, 2, 200); set_push(1, 2, 201);
    step(); clr_push();
    set_push(0, 1, 250);
    step(); clr_push();
    repeat (6) step();

    // R2 R3: backlog on class 2, then two more classes ready in the same cycle as its unit frees
    set_push(0, 2, 5); set_push(1, 2, 6);
    step(); clr_push();
    step(); step();
    set_push(0, 0, 40); set_push(1, 3, 7);
    step(); clr_push();
    repeat (5) step();

    // R3: age tie across classes goes to the lower class index
    set_push(0, 3, 300); set_push(1, 1, 300);
    step(); clr_push();
    repeat (3) step();

    // R4: an older late arrival overtakes the existing backlog of its class
    set_push(0, 2, 500); set_push(1, 2, 501);
    step(); clr_push();
    set_push(0, 2, 502); set_push(1, 2, 10);
    step(); clr_push();
    repeat (14) step();

    // R6 R7: mixed random traffic, pools never overfilled
    for (int cyc = 0; cyc < 4000; cyc++) begin
      int occ [NC];
      clr_push();
      for (int c = 0; c < NC; c++) begin
        occ[c] = 0;
        for (int i = 0; i < QD; i++) if (rq_v[c][i]) occ[c]++;
      end
      for (int p = 0; p < P; p++) begin
        if ($urandom_range(0, 99) < 55) begin
          int c;
          c = int'($urandom_range(0, NC - 1));
          if (occ[c] < QD) begin
            set_push(p, c, int'($urandom_range(0, 4095)));
            occ[c]++;
          end
        end
      end
      step();
    end
    clr_push();
    repeat (40) step();

    finished = 1'b1;
    report();
    $finish;
  end

endmodule